// File: doc/BRIEF.md
# Streaming Single-Pattern String Matcher

This block scans a byte stream for one exact pattern of up to 16 characters. Characters enter through a valid/ready handshake into a small FIFO. A matching engine reads the FIFO head and tracks how many pattern characters are currently matched. When a comparison fails, it falls back through a failure table that is computed elsewhere and loaded into the block. No input character is ever read twice.

Each cycle the engine runs two equality tests on the same buffered character. The first test is against the pattern character at the current match length. The second is against the pattern character at that length's fallback. This lets the engine resolve a mismatch and one fallback step in a single cycle. A cycle that takes neither branch drops the match length by at least two and leaves the character in the FIFO. The FIFO absorbs these stall cycles, so input keeps flowing.

The pattern, its failure table and its length can be rewritten at run time through a configuration port. Every configuration write discards buffered input and restarts matching and position counting. Each completed match gives a one-cycle pulse together with the stream position of the match's last character.

Top module: `kmp_matcher`

## Requirements
- R1: After reset, in_ready_o is high, match_o is low and the stored pattern length is zero.
- R2: For every input position p, counted from 0 at the first character accepted after the latest configuration write, where the last L accepted characters equal the loaded pattern of length L, match_o pulses for exactly one cycle with match_pos_o equal to p. No pulse occurs otherwise.
- R3: Overlapping occurrences are all reported; after a match the match length continues from the failure value of the full pattern.
- R4: When the primary comparison misses but the fallback comparison hits, the character is consumed in that same cycle. When both miss and the fallback length is nonzero, the character stays buffered and the match length strictly decreases.
- R5: in_ready_o is low only while the FIFO holds BUF_DEPTH characters or cfg_we_i is high; a continuous stream no longer than BUF_DEPTH is never stalled.
- R6: For a continuous stream of n characters with n at most twice BUF_DEPTH, the last match pulse appears no later than n + BUF_DEPTH + 2 cycles after the first character is accepted.
- R7: A cycle with cfg_we_i high writes pattern[cfg_addr_i] (address below MAXLEN), fail[cfg_addr_i] (address up to MAXLEN) and the length (cfg_len_i, clamped to MAXLEN). It also empties the FIFO, zeroes the match length and position counter, and suppresses any pending match.
- R8: Pattern lengths of 1 and of MAXLEN (16) both match correctly, including back-to-back matches of a one-character pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input character valid |
| in_data_i | input | DW | Input character |
| in_ready_o | output | 1 | Block can accept a character this cycle |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | LEN_W | Table index for the write |
| cfg_char_i | input | DW | Pattern character written at cfg_addr_i |
| cfg_fail_i | input | LEN_W | Failure value written at cfg_addr_i |
| cfg_len_i | input | LEN_W | Pattern length |
| match_o | output | 1 | One-cycle match pulse |
| match_pos_o | output | POS_W | Position of the last character of the match |

## Verification
The assertions assume the failure table loaded for length L is a proper one. That means fail[0] and fail[1] are zero and fail[j] is below j for every j up to L, so the match length never reaches L between matches and each retry lowers it. The bench meets this by computing every table from its own prefix-function routine before loading it. It also holds in_valid_i low while it writes a table. Its expected matches come from a direct window comparison over the accepted characters, which is independent of how the engine falls back.

// File: rtl/kmp_pkg.sv
package kmp_pkg;
    // Decision taken by the engine for the character at the buffer head
    typedef enum logic [2:0] {
        STEP_IDLE,     // nothing buffered, or clearing
        STEP_ADV,      // primary comparison hit, extend the match
        STEP_JUMP,     // fallback comparison hit, consume in one cycle
        STEP_RESTART,  // no prefix can continue, consume with length zero
        STEP_RETRY     // both missed, keep the character, shorten the match
    } step_e;
endpackage

// File: rtl/kmp_buffer.sv
module kmp_buffer #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          push_i,
    input  logic [DW-1:0] data_i,
    input  logic          pop_i,
    output logic          full_o,
    output logic          empty_o,
    output logic [DW-1:0] head_o,
    output logic [CW-1:0] cnt_o
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } buf_t;

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    buf_t          st_q, st_d;
    logic [DW-1:0] mem_q [DEPTH];
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (st_q.cnt == CW'(DEPTH));
    assign empty_o = (st_q.cnt == '0);
    assign head_o  = mem_q[st_q.rd];
    assign cnt_o   = st_q.cnt;
    assign do_push = push_i && !full_o && !clear_i;
    assign do_pop  = pop_i && !empty_o && !clear_i;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = step_ptr(st_q.wr);
            if (do_pop)  st_d.rd = step_ptr(st_q.rd);
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= data_i;
    end
endmodule

// File: rtl/kmp_store.sv
module kmp_store #(
    parameter int DW     = 8,
    parameter int MAXLEN = 16,
    parameter int LEN_W  = 5,
    localparam int TAB_N = 1 << LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [LEN_W-1:0] addr_i,
    input  logic [DW-1:0]    char_i,
    input  logic [LEN_W-1:0] fail_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [LEN_W-1:0] j_i,
    output logic [LEN_W-1:0] len_o,
    output logic [DW-1:0]    pat_j_o,
    output logic [LEN_W-1:0] fail_j_o,
    output logic [DW-1:0]    pat_f_o,
    output logic [LEN_W-1:0] fail_f_o,
    output logic [LEN_W-1:0] fail_len_o
);
    localparam logic [LEN_W-1:0] LMAX = LEN_W'(MAXLEN);

    logic [DW-1:0]    pat_q  [TAB_N];
    logic [DW-1:0]    pat_d  [TAB_N];
    logic [LEN_W-1:0] fail_q [TAB_N];
    logic [LEN_W-1:0] fail_d [TAB_N];
    logic [LEN_W-1:0] len_q, len_d;

    always_comb begin
        pat_d  = pat_q;
        fail_d = fail_q;
        len_d  = len_q;
        if (we_i) begin
            if (addr_i < LMAX)  pat_d[addr_i]  = char_i;
            if (addr_i <= LMAX) fail_d[addr_i] = fail_i;
            len_d = (len_i > LMAX) ? LMAX : len_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q  <= '{default: '0};
            fail_q <= '{default: '0};
            len_q  <= '0;
        end else begin
            pat_q  <= pat_d;
            fail_q <= fail_d;
            len_q  <= len_d;
        end
    end

    // Two read chains: current length and its fallback
    assign len_o      = len_q;
    assign pat_j_o    = pat_q[j_i];
    assign fail_j_o   = fail_q[j_i];
    assign pat_f_o    = pat_q[fail_j_o];
    assign fail_f_o   = fail_q[fail_j_o];
    assign fail_len_o = fail_q[len_q];
endmodule

// File: rtl/kmp_engine.sv
module kmp_engine
    import kmp_pkg::*;
#(
    parameter int DW    = 8,
    parameter int LEN_W = 5,
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             have_i,
    input  logic [DW-1:0]    char_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [DW-1:0]    pat_j_i,
    input  logic [LEN_W-1:0] fail_j_i,
    input  logic [DW-1:0]    pat_f_i,
    input  logic [LEN_W-1:0] fail_f_i,
    input  logic [LEN_W-1:0] fail_len_i,
    output logic [LEN_W-1:0] j_o,
    output logic             consume_o,
    output logic             retry_o,
    output logic             match_o,
    output logic [POS_W-1:0] match_pos_o
);
    typedef struct packed {
        logic [LEN_W-1:0] j;
        logic [POS_W-1:0] pos;
        logic             hit;
        logic [POS_W-1:0] hit_pos;
    } eng_t;

    eng_t             st_q, st_d;
    step_e            step;
    logic [LEN_W-1:0] nxt_j;
    logic             consume;

    always_comb begin
        step  = STEP_IDLE;
        nxt_j = '0;
        if (!clear_i && have_i) begin
            if (len_i == '0) begin
                step = STEP_RESTART;
            end else if (char_i == pat_j_i) begin
                step  = STEP_ADV;
                nxt_j = st_q.j + 1'b1;
            end else if (st_q.j == '0) begin
                step = STEP_RESTART;
            end else if (char_i == pat_f_i) begin
                step  = STEP_JUMP;
                nxt_j = fail_j_i + 1'b1;
            end else if (fail_j_i == '0) begin
                step = STEP_RESTART;
            end else begin
                step  = STEP_RETRY;
                nxt_j = fail_f_i;
            end
        end
        consume = (step == STEP_ADV) || (step == STEP_JUMP) || (step == STEP_RESTART);

        st_d     = st_q;
        st_d.hit = 1'b0;
        if (clear_i) begin
            st_d = '0;
        end else if (step == STEP_RETRY) begin
            st_d.j = nxt_j;
        end else if (consume) begin
            st_d.pos = st_q.pos + 1'b1;
            if ((len_i != '0) && (nxt_j == len_i)) begin
                st_d.hit     = 1'b1;
                st_d.hit_pos = st_q.pos;
                st_d.j       = fail_len_i;
            end else begin
                st_d.j = nxt_j;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign j_o         = st_q.j;
    assign consume_o   = consume;
    assign retry_o     = (step == STEP_RETRY);
    assign match_o     = st_q.hit;
    assign match_pos_o = st_q.hit_pos;
endmodule

// File: rtl/kmp_matcher.sv
module kmp_matcher #(
    parameter int DW        = 8,
    parameter int MAXLEN    = 16,
    parameter int BUF_DEPTH = MAXLEN,
    parameter int POS_W     = 16,
    localparam int LEN_W    = $clog2(MAXLEN + 1),
    localparam int CW       = $clog2(BUF_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid_i,
    input  logic [DW-1:0]    in_data_i,
    output logic             in_ready_o,
    input  logic             cfg_we_i,
    input  logic [LEN_W-1:0] cfg_addr_i,
    input  logic [DW-1:0]    cfg_char_i,
    input  logic [LEN_W-1:0] cfg_fail_i,
    input  logic [LEN_W-1:0] cfg_len_i,
    output logic             match_o,
    output logic [POS_W-1:0] match_pos_o
);
    logic             buf_full, buf_empty;
    logic [DW-1:0]    head;
    logic [CW-1:0]    buf_cnt;
    logic [LEN_W-1:0] j_q, len_q;
    logic [DW-1:0]    pat_j, pat_f;
    logic [LEN_W-1:0] fail_j, fail_f, fail_len;
    logic             consume, retry;

    assign in_ready_o = !buf_full && !cfg_we_i;

    kmp_buffer #(.DW(DW), .DEPTH(BUF_DEPTH)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cfg_we_i),
        .push_i  (in_valid_i && in_ready_o),
        .data_i  (in_data_i),
        .pop_i   (consume),
        .full_o  (buf_full),
        .empty_o (buf_empty),
        .head_o  (head),
        .cnt_o   (buf_cnt)
    );

    kmp_store #(.DW(DW), .MAXLEN(MAXLEN), .LEN_W(LEN_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cfg_we_i),
        .addr_i     (cfg_addr_i),
        .char_i     (cfg_char_i),
        .fail_i     (cfg_fail_i),
        .len_i      (cfg_len_i),
        .j_i        (j_q),
        .len_o      (len_q),
        .pat_j_o    (pat_j),
        .fail_j_o   (fail_j),
        .pat_f_o    (pat_f),
        .fail_f_o   (fail_f),
        .fail_len_o (fail_len)
    );

    kmp_engine #(.DW(DW), .LEN_W(LEN_W), .POS_W(POS_W)) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (cfg_we_i),
        .have_i      (!buf_empty),
        .char_i      (head),
        .len_i       (len_q),
        .pat_j_i     (pat_j),
        .fail_j_i    (fail_j),
        .pat_f_i     (pat_f),
        .fail_f_i    (fail_f),
        .fail_len_i  (fail_len),
        .j_o         (j_q),
        .consume_o   (consume),
        .retry_o     (retry),
        .match_o     (match_o),
        .match_pos_o (match_pos_o)
    );
endmodule

// File: rtl/kmp_matcher_chk.sv
module kmp_matcher_chk #(
    parameter int DEPTH = 16,
    parameter int LEN_W = 5,
    parameter int CW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready_o,
    input logic             cfg_we_i,
    input logic             match_o,
    input logic [CW-1:0]    buf_cnt,
    input logic [LEN_W-1:0] j_q,
    input logic [LEN_W-1:0] len_q,
    input logic             consume,
    input logic             retry
);
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_cnt <= CW'(DEPTH));

    // R5
    stall_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready_o && !cfg_we_i) |-> (buf_cnt == CW'(DEPTH)));

    // R2
    match_from_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(consume));

    // R4
    retry_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry |=> (j_q < $past(j_q)));

    // R3
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q != '0) |-> (j_q < len_q));

    // R7
    cfg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> ((buf_cnt == '0) && (j_q == '0) && !match_o));
endmodule

bind kmp_matcher kmp_matcher_chk #(.DEPTH(BUF_DEPTH), .LEN_W(LEN_W), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready_o (in_ready_o),
    .cfg_we_i   (cfg_we_i),
    .match_o    (match_o),
    .buf_cnt    (buf_cnt),
    .j_q        (j_q),
    .len_q      (len_q),
    .consume    (consume),
    .retry      (retry)
);

// File: tb/kmp_matcher_tb.sv
`timescale 1ns/1ps
module kmp_matcher_tb;
    localparam int DW = 8, MAXLEN = 16, BUF_DEPTH = 16, POS_W = 16;
    localparam int LEN_W = $clog2(MAXLEN + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, cfg_we = 1'b0;
    logic [DW-1:0] in_data = '0, cfg_char = '0;
    logic [LEN_W-1:0] cfg_addr = '0, cfg_fail = '0, cfg_len = '0;
    logic in_ready, match;
    logic [POS_W-1:0] match_pos;

    always #10 clk = ~clk;

    kmp_matcher #(.DW(DW), .MAXLEN(MAXLEN), .BUF_DEPTH(BUF_DEPTH), .POS_W(POS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
        .in_ready_o(in_ready), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
        .cfg_char_i(cfg_char), .cfg_fail_i(cfg_fail), .cfg_len_i(cfg_len),
        .match_o(match), .match_pos_o(match_pos)
    );

    int checks = 0, errors = 0, cyc = 0;
    int first_acc = 0, last_hit = 0;
    bit done = 0;
    string pat = "";
    string cur_req = "R2";
    byte hist[$];
    int  expq[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            check(0, "watchdog", cyc, 100000);
            summary();
        end
    end

    // Monitor: pops expected positions as matches appear
    always @(negedge clk) begin
        if (rst_n && match) begin
            last_hit = cyc;
            if (expq.size() == 0) begin
                check(0, {cur_req, " unexpected match"}, int'(match_pos), -1);
            end else begin
                int e;
                e = expq.pop_front();
                check(int'(match_pos) == e, {cur_req, " match position"}, int'(match_pos), e);
            end
        end
    end

    // R7: load pattern, failure table and length; bench computes the table
    task automatic load(input string p);
        int L, k;
        int f[MAXLEN+1];
        L = p.len();
        k = 0;
        f[0] = 0;
        if (L > 0) f[1] = 0;
        for (int i = 1; i < L; i++) begin
            while (k > 0 && p[i] != p[k]) k = f[k];
            if (p[i] == p[k]) k++;
            f[i+1] = k;
        end
        for (int a = 0; a <= L; a++) begin
            @(negedge clk);
            in_valid = 1'b0;
            cfg_we   = 1'b1;
            cfg_addr = LEN_W'(a);
            cfg_char = (a < L) ? p[a] : 8'h00;
            cfg_fail = LEN_W'(f[a]);
            cfg_len  = LEN_W'(L);
        end
        @(negedge clk);
        cfg_we = 1'b0;
        pat = p;
        hist.delete();
    endtask

    // Driver: pushes characters and the positions where a match must appear
    task automatic send(input string s, output int stalls);
        stalls = 0;
        for (int i = 0; i < s.len(); i++) begin
            bit acc;
            acc = 0;
            while (!acc) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_data  = s[i];
                acc = in_ready;
                if (!acc) stalls++;
            end
            if (i == 0) first_acc = cyc;
            hist.push_back(s[i]);
            if (pat.len() > 0 && hist.size() >= pat.len()) begin
                bit eq;
                eq = 1;
                for (int m = 0; m < pat.len(); m++)
                    if (hist[hist.size() - pat.len() + m] != pat[m]) eq = 0;
                if (eq) expq.push_back(hist.size() - 1);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        repeat (3 * BUF_DEPTH + 8) @(negedge clk);
        check(expq.size() == 0, {req, " all expected matches seen"}, expq.size(), 0);
    endtask

    initial begin
        int st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        check(match == 1'b0, "R1 no match after reset", match, 0);

        // R2 R3: overlapping occurrences
        cur_req = "R3";
        load("abab");
        send("abababxabab", st);
        drain("R3");

        // R4: fallbacks with both single-cycle jumps and retries
        cur_req = "R4";
        load("aabaaab");
        send("aabaabaaabaaab", st);
        drain("R4");

        // R8: single-character pattern, back-to-back hits
        cur_req = "R8";
        load("z");
        send("zzaz", st);
        drain("R8");

        // R8: full-length pattern after a false start
        load("abcdefghijklmnop");
        send("abcabcdefghijklmnopq", st);
        drain("R8");

        // R7: reload discards buffered input and restarts positions
        cur_req = "R7";
        load("abc");
        send("ab", st);
        load("abc");
        send("cabc", st);
        drain("R7");

        // R5 R6: retry-heavy stream, 16 characters with continuous valid
        cur_req = "R6";
        load("aaaaaaab");
        send("aaaaaaacaaaaaaab", st);
        check(st == 0, "R5 stalls on short stream", st, 0);
        drain("R6");
        check((last_hit - first_acc) <= 16 + BUF_DEPTH + 2, "R6 finish bound",
              last_hit - first_acc, 16 + BUF_DEPTH + 2);

        // R2: plain stream with no occurrence and a late one
        cur_req = "R2";
        load("needle");
        send("haystackneedlneedle", st);
        drain("R2");

        summary();
    end
endmodule